// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block records the value of a running counter when a chosen input makes a chosen transition. There are two event inputs: a capture pin and a comparator output. A source select picks one of them. The chosen input passes through a two-flop synchroniser. It then passes through an optional spike filter, and an edge detector follows. On a qualifying transition the edge detector copies the counter value into a capture register. The same transition sets a sticky capture flag. That flag drives an interrupt line through a mask.

Software can also write the capture register. When the counter uses the register as its TOP (period) value, hardware capture is switched off. In that mode the register changes only through software writes, so the period stays fixed.

The spike filter is a two-state machine. In `FLT_STEADY` the filtered level matches the synchronised input. When the input differs from the filtered level, the transition *steady→pending* fires and a run counter starts at 1. In `FLT_PEND`, a sample that matches the filtered level fires *pending→steady (reject)* and the run is dropped. If the input still differs once the run has reached the filter length, *pending→steady (accept)* fires and the new level is taken. Otherwise the machine stays in `FLT_PEND` and counts up. When the filter is disabled, the machine is held in `FLT_STEADY` and the filtered level follows the input on every cycle.

Top module: `cap_unit`

## Requirements
- R1: With the filter off, suppose a qualifying transition of the selected input is applied before rising edge k. Then after edge k+2, `cap_val` holds the `cnt_val` value present at edge k+2, and `cap_flag` is 1. After edge k+1, `cap_flag` is still 0.
- R2: `src_sel`=0 selects `pin_evt` and `src_sel`=1 selects `cmp_evt`. Transitions on the input that is not selected cause no capture.
- R3: `edge_rise`=1 captures on a 0→1 transition only. `edge_rise`=0 captures on a 1→0 transition only. The opposite transition causes no capture.
- R4: With `filt_en`=1, a new level is accepted only after it has been held for 4 consecutive clock samples. A pulse of 3 cycles or fewer causes no capture. An accepted transition applied before edge k captures the `cnt_val` value at edge k+6, which is 4 cycles later than R1.
- R5: `cap_irq` is 1 exactly when `cap_flag` is 1 and `irq_mask` is 1.
- R6: A `flag_clr` pulse sampled at an edge clears `cap_flag`. If a capture occurs at the same edge, the capture wins and the flag stays 1. The flag otherwise stays set.
- R7: With `top_sel`=1, input transitions neither load the register nor set the flag. `cap_val` changes only through `wr_cap_en` writes.
- R8: A `wr_cap_en` pulse loads `wr_cap_data` into `cap_val` at the next edge. If a hardware capture occurs at the same edge, the counter value is loaded instead.
- R9: After reset, `cap_val` is 0, `cap_flag` is 0 and `cap_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Running counter value |
| pin_evt | input | 1 | Capture pin event input (asynchronous) |
| cmp_evt | input | 1 | Comparator output event input (asynchronous) |
| src_sel | input | 1 | 0: pin, 1: comparator |
| edge_rise | input | 1 | 1: rising edge, 0: falling edge |
| filt_en | input | 1 | Enables the spike filter |
| top_sel | input | 1 | Register serves as TOP; hardware capture off |
| wr_cap_en | input | 1 | Software write strobe for the capture register |
| wr_cap_data | input | 16 | Software write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_mask | input | 1 | Interrupt enable |
| cap_val | output | 16 | Capture register / TOP value |
| cap_flag | output | 1 | Capture flag |
| cap_irq | output | 1 | Masked interrupt request |

## Verification
Without the filter, a transition lands in `cap_val` and `cap_flag` 3 edges after it is applied. Two of those edges are the synchroniser and one is the edge register. With the filter on, the result is due 7 edges after the transition. Writes, flag clears and interrupt gating take effect one edge after the strobe. Inputs are driven on the falling clock edge, and the bench counter advances on rising edges. Each expected capture value is therefore the counter value seen when the stimulus was applied, plus 2 or plus 6. Every check samples on the falling edge where the result is first due, and checks the cycle before it where the latency itself is under test.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [0:0] {
        FLT_STEADY = 1'b0,
        FLT_PEND   = 1'b1
    } flt_state_e;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/cap_filter.sv
module cap_filter
    import cap_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);

    localparam int CW = $clog2(FILT_LEN) + 1;

    flt_state_e  state_q, state_d;
    logic [CW-1:0] run_q;
    logic        lvl_q;
    logic        diff, run_done, accept;

    assign diff     = (din != lvl_q);
    assign run_done = (run_q == CW'(FILT_LEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_STEADY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = FLT_STEADY;
        end else begin
            unique case (state_q)
                FLT_STEADY: if (diff) state_d = FLT_PEND;
                FLT_PEND:   if (!diff || run_done) state_d = FLT_STEADY;
                default:    state_d = FLT_STEADY;
            endcase
        end
    end

    assign accept = !en || (state_q == FLT_PEND && diff && run_done);

    // outputs: run length and accepted level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            if (state_d == FLT_PEND)
                run_q <= (state_q == FLT_STEADY) ? CW'(1) : run_q + CW'(1);
            else
                run_q <= '0;
            if (accept)
                lvl_q <= din;
        end
    end

    assign dout = en ? lvl_q : din;

endmodule

// File: rtl/cap_core.sv
module cap_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic             edge_rise,
    input  logic             top_sel,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    input  logic             irq_mask,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             cap_irq,
    output logic             hit
);

    logic prev_q;
    logic rise, fall;

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
    assign hit  = (edge_rise ? rise : fall) & ~top_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            cap_val  <= '0;
            cap_flag <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (hit)        cap_val <= cnt_val;
            else if (wr_en) cap_val <= wr_data;
            if (hit)           cap_flag <= 1'b1;
            else if (flag_clr) cap_flag <= 1'b0;
        end
    end

    assign cap_irq = cap_flag & irq_mask;

endmodule

// File: rtl/cap_unit.sv
module cap_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             pin_evt,
    input  logic             cmp_evt,
    input  logic             src_sel,
    input  logic             edge_rise,
    input  logic             filt_en,
    input  logic             top_sel,
    input  logic             wr_cap_en,
    input  logic [CNT_W-1:0] wr_cap_data,
    input  logic             flag_clr,
    input  logic             irq_mask,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             cap_irq
);

    logic [1:0] raw_in, sync_in;
    logic       sel_lvl, flt_lvl, cap_hit;

    assign raw_in = {cmp_evt, pin_evt};

    cap_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    assign sel_lvl = src_sel ? sync_in[1] : sync_in[0];

    cap_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (filt_en),
        .din   (sel_lvl),
        .dout  (flt_lvl)
    );

    cap_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (flt_lvl),
        .edge_rise (edge_rise),
        .top_sel   (top_sel),
        .cnt_val   (cnt_val),
        .wr_en     (wr_cap_en),
        .wr_data   (wr_cap_data),
        .flag_clr  (flag_clr),
        .irq_mask  (irq_mask),
        .cap_val   (cap_val),
        .cap_flag  (cap_flag),
        .cap_irq   (cap_irq),
        .hit       (cap_hit)
    );

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             top_sel,
    input logic             wr_cap_en,
    input logic [CNT_W-1:0] wr_cap_data,
    input logic             flag_clr,
    input logic             irq_mask,
    input logic             hit,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             cap_irq
);

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_flag && cap_val == $past(cnt_val)); // R1

    AST_TOP_BLOCKS_HW: assert property (@(posedge clk) disable iff (!rst_n)
        top_sel |-> !hit); // R7

    AST_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        top_sel && !wr_cap_en |=> cap_val == $past(cap_val)); // R7

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cap_en && !hit |=> cap_val == $past(wr_cap_data)); // R8

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !hit |=> !cap_flag); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_flag && !flag_clr |=> cap_flag); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> cap_flag && irq_mask); // R5

endmodule

bind cap_unit cap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_val     (cnt_val),
    .top_sel     (top_sel),
    .wr_cap_en   (wr_cap_en),
    .wr_cap_data (wr_cap_data),
    .flag_clr    (flag_clr),
    .irq_mask    (irq_mask),
    .hit         (cap_hit),
    .cap_val     (cap_val),
    .cap_flag    (cap_flag),
    .cap_irq     (cap_irq)
);

// File: tb/cap_unit_test.sv
module cap_unit_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_q = '0;
    logic        pin_evt = 0, cmp_evt = 0, src_sel = 0, edge_rise = 1, filt_en = 0;
    logic        top_sel = 0, wr_cap_en = 0, flag_clr = 0, irq_mask = 0;
    logic [15:0] wr_cap_data = '0;
    logic [15:0] cap_val;
    logic        cap_flag, cap_irq;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= 16'd100;
        else        cnt_q <= cnt_q + 16'd1;
    end

    cap_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_val     (cnt_q),
        .pin_evt     (pin_evt),
        .cmp_evt     (cmp_evt),
        .src_sel     (src_sel),
        .edge_rise   (edge_rise),
        .filt_en     (filt_en),
        .top_sel     (top_sel),
        .wr_cap_en   (wr_cap_en),
        .wr_cap_data (wr_cap_data),
        .flag_clr    (flag_clr),
        .irq_mask    (irq_mask),
        .cap_val     (cap_val),
        .cap_flag    (cap_flag),
        .cap_irq     (cap_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag;
        flag_clr = 1; step(1); flag_clr = 0;
    endtask

    task automatic t_reset;
        chk("R9 cap_val", cap_val, 16'h0);
        chk("R9 cap_flag", {15'd0, cap_flag}, 16'd0);
        chk("R9 cap_irq", {15'd0, cap_irq}, 16'd0);
    endtask

    task automatic t_basic;
        logic [15:0] e;
        clear_flag();
        pin_evt = 1; e = cnt_q;
        step(2);
        chk("R1 flag not early", {15'd0, cap_flag}, 16'd0);
        step(1);
        chk("R1 flag set", {15'd0, cap_flag}, 16'd1);
        chk("R1 captured value", cap_val, e + 16'd2);
        pin_evt = 0; step(4);
    endtask

    task automatic t_edges;
        logic [15:0] e;
        logic [15:0] held;
        clear_flag();
        held = cap_val;
        pin_evt = 1; step(5);
        clear_flag();
        held = cap_val;
        pin_evt = 0; step(5);
        chk("R3 fall ignored when rising", {15'd0, cap_flag}, 16'd0);
        chk("R3 value kept", cap_val, held);
        edge_rise = 0;
        pin_evt = 1; step(5);
        chk("R3 rise ignored when falling", {15'd0, cap_flag}, 16'd0);
        pin_evt = 0; e = cnt_q;
        step(3);
        chk("R3 falling capture flag", {15'd0, cap_flag}, 16'd1);
        chk("R3 falling capture value", cap_val, e + 16'd2);
        edge_rise = 1; step(2);
    endtask

    task automatic t_source;
        logic [15:0] e;
        src_sel = 1; step(2);
        clear_flag();
        pin_evt = 1; step(5);
        chk("R2 pin ignored when cmp selected", {15'd0, cap_flag}, 16'd0);
        pin_evt = 0; step(5);
        cmp_evt = 1; e = cnt_q;
        step(3);
        chk("R2 cmp capture flag", {15'd0, cap_flag}, 16'd1);
        chk("R2 cmp capture value", cap_val, e + 16'd2);
        cmp_evt = 0; step(4);
        src_sel = 0; step(2);
    endtask

    task automatic t_filter;
        logic [15:0] e;
        filt_en = 1; step(2);
        clear_flag();
        pin_evt = 1; step(3); pin_evt = 0; step(10);
        chk("R4 3-cycle spike rejected", {15'd0, cap_flag}, 16'd0);
        pin_evt = 1; e = cnt_q;
        step(6);
        chk("R4 no capture before filter delay", {15'd0, cap_flag}, 16'd0);
        step(1);
        chk("R4 filtered capture flag", {15'd0, cap_flag}, 16'd1);
        chk("R4 filtered capture value", cap_val, e + 16'd6);
        pin_evt = 0; step(10);
        filt_en = 0; step(2);
    endtask

    task automatic t_flag;
        logic [15:0] e;
        irq_mask = 0; step(1);
        chk("R5 masked irq low", {15'd0, cap_irq}, 16'd0);
        irq_mask = 1; step(1);
        chk("R5 unmasked irq high", {15'd0, cap_irq}, {15'd0, cap_flag});
        chk("R5 flag still set", {15'd0, cap_flag}, 16'd1);
        pin_evt = 1; e = cnt_q;
        step(2);
        flag_clr = 1; step(1); flag_clr = 0;
        chk("R6 capture beats clear", {15'd0, cap_flag}, 16'd1);
        chk("R6 capture value on clear edge", cap_val, e + 16'd2);
        clear_flag();
        chk("R6 clear drops flag", {15'd0, cap_flag}, 16'd0);
        chk("R5 irq low after clear", {15'd0, cap_irq}, 16'd0);
        pin_evt = 0; step(4);
        irq_mask = 0;
    endtask

    task automatic t_top;
        top_sel = 1;
        wr_cap_en = 1; wr_cap_data = 16'h1234; step(1); wr_cap_en = 0;
        chk("R7 write in TOP mode", cap_val, 16'h1234);
        clear_flag();
        pin_evt = 1; step(5);
        chk("R7 no hw capture in TOP mode", cap_val, 16'h1234);
        chk("R7 no flag in TOP mode", {15'd0, cap_flag}, 16'd0);
        pin_evt = 0; step(5);
        top_sel = 0; step(1);
    endtask

    task automatic t_write;
        logic [15:0] e;
        wr_cap_en = 1; wr_cap_data = 16'hBEEF; step(1); wr_cap_en = 0;
        chk("R8 plain write", cap_val, 16'hBEEF);
        pin_evt = 1; e = cnt_q;
        step(2);
        wr_cap_en = 1; wr_cap_data = 16'h5A5A; step(1); wr_cap_en = 0;
        chk("R8 capture beats write", cap_val, e + 16'd2);
        pin_evt = 0; step(4);
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1;
        step(2);
        t_reset();
        t_basic();
        t_edges();
        t_source();
        t_filter();
        t_flag();
        t_top();
        t_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule